// File: doc/BRIEF.md
# Scalar Unary-Operation Execution Unit

This unit executes one-source scalar instructions held in a 32-bit word. Each word carries a 9-bit encoding tag, an opcode byte, a source register index and a destination register index. The unit checks the tag, decodes the opcode under one of two numbering generations picked by `gen_new`, reads the source from a 16-entry scalar register file and writes the result back. It also updates a one-bit condition flag where the operation calls for it. The operations are move, conditional move, bitwise complement, quad-mask expansion (every 4-bit group holding a set bit becomes all ones) and bit reversal, each in a 32-bit form and in a 64-bit form that works on an aligned register pair.

One instruction can be accepted on every cycle. Its register write and flag update take effect at the accepting clock edge, so the next instruction reads the new values. A completion pulse with an illegal flag follows one cycle later. A separate load port lets a neighbouring unit fill registers, and a peek port returns any register one cycle after its index is presented.

Top module: `scalar_unop_unit`

## Requirements
- R1: A word is executed only when bits 31:23 equal 9'b101111101. Any other tag raises `done_illegal` and changes no register and not the flag.
- R2: Opcode sits in bits 15:8. With `gen_new`=0, opcodes 3..12 mean MOV32, MOV64, CMOV32, CMOV64, NOT32, NOT64, QMASK32, QMASK64, REV32, REV64. With `gen_new`=1 the same ten operations take opcodes 0..9. Every other opcode is illegal and changes no state.
- R3: MOV copies the source to the destination and leaves the flag unchanged.
- R4: CMOV writes the source only while the flag is 1. When the flag is 0 the destination keeps its value. The flag is never changed.
- R5: NOT writes the bitwise complement of the source. The flag becomes 1 when the result is non-zero and 0 otherwise.
- R6: QMASK makes each aligned 4-bit group of the result all ones if that group of the source has any bit set, and all zeros otherwise. The flag becomes 1 when the result is non-zero.
- R7: REV writes the source with its bit order mirrored across the full operand width (32 or 64 bits). The flag is unchanged.
- R8: The source index is bits 7:0 and the destination index is bits 22:16. An index of 16 or more is illegal. A 64-bit operand uses registers n (low word) and n+1 (high word). An odd n in a 64-bit operation is illegal.
- R9: `in_ready` is 1 on every cycle after reset. For each accepted word, `done_valid` pulses on the next cycle. The register write and flag update are visible from that same cycle.
- R10: A synchronous reset clears the flag, `done_valid` and `done_illegal`, and holds `in_ready` at 0.
- R11: `ld_en` writes `ld_data` into register `ld_idx`. `peek_data` shows register `peek_idx` one cycle after the index is presented. An instruction write to the same bank in the same cycle takes priority over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_new | input | 1 | Opcode numbering: 0 older, 1 newer |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit accepts a word this cycle |
| in_word | input | 32 | Instruction word |
| done_valid | output | 1 | Pulse one cycle after acceptance |
| done_illegal | output | 1 | The completed word was rejected |
| scc | output | 1 | Condition flag |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 4 | Register loaded |
| ld_data | input | 32 | Load value |
| peek_idx | input | 4 | Register to observe |
| peek_data | output | 32 | Observed register, one cycle later |

## Verification
All 256 opcode values are swept under both generations. This separates the ten legal codes of each generation from every rejected code. Each operation then runs in both widths on operand patterns chosen to tell the operations apart: zero, all ones, a lone low bit, a lone top bit, a mixed word, and a sparse word where only some nibbles are set. The zero and all-ones operands decide the flag for NOT and QMASK. The lone-bit operands expose a reversal done at the wrong width and a half-word swap in register pairs. CMOV is run with the flag at both values. Corrupted tags, odd pair indices and out-of-range indices must leave the destination and the flag untouched.

// File: rtl/sunop_pkg.sv
package sunop_pkg;
  typedef enum logic [2:0] {
    OP_MOV  = 3'd0,
    OP_CMOV = 3'd1,
    OP_NOT  = 3'd2,
    OP_QMSK = 3'd3,
    OP_REV  = 3'd4
  } sop_e;

  localparam logic [8:0] ENC_TAG     = 9'b101111101;
  localparam int         OPS_PER_GEN = 10;
  localparam logic [7:0] OLD_BASE    = 8'd3;
  localparam logic [7:0] NEW_BASE    = 8'd0;
  localparam int         GROUP_W     = 4;
endpackage

// File: rtl/scalar_unop_decode.sv
module scalar_unop_decode
  import sunop_pkg::*;
(
  input  logic       gen_new,
  input  logic [7:0] opcode,
  output logic       op_ok,
  output sop_e       op,
  output logic       wide
);
  logic [7:0] base;
  logic [7:0] rel;

  always_comb begin
    base  = gen_new ? NEW_BASE : OLD_BASE;
    rel   = opcode - base;
    op_ok = (opcode >= base) && (rel < 8'(OPS_PER_GEN));
    op    = sop_e'(rel[3:1]);
    wide  = rel[0];
  end
endmodule

// File: rtl/scalar_unop_alu.sv
module scalar_unop_alu
  import sunop_pkg::*;
#(
  parameter int W = 32
) (
  input  sop_e             op,
  input  logic             wide,
  input  logic [2*W-1:0]   src,
  input  logic             scc_in,
  output logic [2*W-1:0]   res,
  output logic             do_wr,
  output logic             scc_we,
  output logic             scc_nv
);
  localparam int DW = 2 * W;
  localparam int NG = DW / GROUP_W;

  logic [DW-1:0] mask;
  logic [DW-1:0] opnd;
  logic [DW-1:0] qm;
  logic [DW-1:0] rev64;
  logic [W-1:0]  rev32;

  always_comb begin
    mask = wide ? {DW{1'b1}} : {{W{1'b0}}, {W{1'b1}}};
    opnd = src & mask;
    qm   = '0;
    for (int g = 0; g < NG; g++)
      qm[g*GROUP_W +: GROUP_W] = {GROUP_W{|opnd[g*GROUP_W +: GROUP_W]}};
    for (int i = 0; i < DW; i++) rev64[i] = opnd[DW-1-i];
    for (int i = 0; i < W; i++)  rev32[i] = opnd[W-1-i];
  end

  always_comb begin
    res    = opnd;
    do_wr  = 1'b1;
    scc_we = 1'b0;
    case (op)
      OP_MOV:  res = opnd;
      OP_CMOV: do_wr = scc_in;
      OP_NOT: begin
        res    = ~opnd & mask;
        scc_we = 1'b1;
      end
      OP_QMSK: begin
        res    = qm;
        scc_we = 1'b1;
      end
      OP_REV:  res = wide ? rev64 : {{W{1'b0}}, rev32};
      default: do_wr = 1'b0;
    endcase
    scc_nv = |res;
  end
endmodule

// File: rtl/scalar_unop_regfile.sv
module scalar_unop_regfile #(
  parameter int W      = 32,
  parameter int NREG   = 16,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_wide,
  output logic [2*W-1:0]   rd_data,
  input  logic             w_en,
  input  logic [IDX_W-1:0] w_idx,
  input  logic             w_wide,
  input  logic [2*W-1:0]   w_data,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [W-1:0]     ld_data,
  input  logic [IDX_W-1:0] pk_idx,
  output logic [W-1:0]     pk_data
);
  localparam int ROWS  = NREG / 2;
  localparam int ROW_W = IDX_W - 1;

  logic [W-1:0] rd_bank [2];
  logic [W-1:0] pk_bank [2];
  logic         pk_sel_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [W-1:0] mem [ROWS];
    logic         inst_we;
    logic         load_we;
    logic [W-1:0] inst_d;
    logic [W-1:0] pk_q;

    assign inst_we = w_en && (w_wide || (w_idx[0] == 1'(b)));
    assign load_we = ld_en && (ld_idx[0] == 1'(b));
    assign inst_d  = (w_wide && b == 1) ? w_data[2*W-1:W] : w_data[W-1:0];

    always_ff @(posedge clk) begin
      if (inst_we)      mem[w_idx[IDX_W-1:1]]  <= inst_d;
      else if (load_we) mem[ld_idx[IDX_W-1:1]] <= ld_data;
      pk_q <= mem[pk_idx[IDX_W-1:1]];
    end

    assign rd_bank[b] = mem[rd_idx[IDX_W-1:1]];
    assign pk_bank[b] = pk_q;
  end

  always_ff @(posedge clk) pk_sel_q <= pk_idx[0];

  assign pk_data = pk_bank[pk_sel_q];
  assign rd_data = rd_wide ? {rd_bank[1], rd_bank[0]}
                           : {{W{1'b0}}, rd_bank[rd_idx[0]]};

  AST_PAIR_WRITE_EVEN: assert property (@(posedge clk) disable iff (rst)
    (w_en && w_wide) |-> !w_idx[0]); // R8

  logic [ROW_W-1:0] unused_row;
  assign unused_row = '0;
endmodule

// File: rtl/scalar_unop_unit.sv
module scalar_unop_unit
  import sunop_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int REG_COUNT = 16,
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_new,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  output logic              done_valid,
  output logic              done_illegal,
  output logic              scc,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  peek_idx,
  output logic [WORD_W-1:0] peek_data
);
  logic [7:0] f_src;
  logic [6:0] f_dst;
  logic [7:0] f_opc;
  logic [8:0] f_tag;

  logic         rdy_q;
  logic         scc_q;
  logic         fire;
  logic         tag_ok;
  logic         idx_ok;
  logic         align_ok;
  logic         exec_ok;
  logic         dec_ok;
  sop_e         dec_op;
  logic         dec_wide;
  logic [2*WORD_W-1:0] src_val;
  logic [2*WORD_W-1:0] alu_res;
  logic         alu_wr;
  logic         alu_scc_we;
  logic         alu_scc_nv;

  assign f_src = in_word[7:0];
  assign f_opc = in_word[15:8];
  assign f_dst = in_word[22:16];
  assign f_tag = in_word[31:23];

  assign fire     = in_valid && rdy_q;
  assign tag_ok   = (f_tag == ENC_TAG);
  assign idx_ok   = (f_src[7:IDX_W] == '0) && (f_dst[6:IDX_W] == '0);
  assign align_ok = !dec_wide || (!f_src[0] && !f_dst[0]);
  assign exec_ok  = tag_ok && dec_ok && idx_ok && align_ok;

  scalar_unop_decode u_dec (
    .gen_new (gen_new),
    .opcode  (f_opc),
    .op_ok   (dec_ok),
    .op      (dec_op),
    .wide    (dec_wide)
  );

  scalar_unop_regfile #(.W(WORD_W), .NREG(REG_COUNT)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (f_src[IDX_W-1:0]),
    .rd_wide (dec_wide),
    .rd_data (src_val),
    .w_en    (fire && exec_ok && alu_wr),
    .w_idx   (f_dst[IDX_W-1:0]),
    .w_wide  (dec_wide),
    .w_data  (alu_res),
    .ld_en   (ld_en),
    .ld_idx  (ld_idx),
    .ld_data (ld_data),
    .pk_idx  (peek_idx),
    .pk_data (peek_data)
  );

  scalar_unop_alu #(.W(WORD_W)) u_alu (
    .op     (dec_op),
    .wide   (dec_wide),
    .src    (src_val),
    .scc_in (scc_q),
    .res    (alu_res),
    .do_wr  (alu_wr),
    .scc_we (alu_scc_we),
    .scc_nv (alu_scc_nv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q        <= 1'b0;
      scc_q        <= 1'b0;
      done_valid   <= 1'b0;
      done_illegal <= 1'b0;
    end else begin
      rdy_q        <= 1'b1;
      done_valid   <= fire;
      done_illegal <= fire && !exec_ok;
      if (fire && exec_ok && alu_scc_we) scc_q <= alu_scc_nv;
    end
  end

  assign in_ready = rdy_q;
  assign scc      = scc_q;

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> done_valid); // R9
  AST_ILLEGAL_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    done_illegal |-> (scc_q == $past(scc_q))); // R1
  AST_MOV_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (fire && exec_ok && dec_op == OP_MOV) |=> $stable(scc_q)); // R3
  AST_CMOV_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (fire && exec_ok && dec_op == OP_CMOV) |=> $stable(scc_q)); // R4
  AST_REV_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (fire && exec_ok && dec_op == OP_REV) |=> $stable(scc_q)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid || $past(in_valid)); // R9
endmodule

// File: tb/scalar_unop_unit_bench.sv
module scalar_unop_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gen_new = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        done_valid;
  logic        done_illegal;
  logic        scc;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic [3:0]  peek_idx = '0;
  logic [31:0] peek_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] ref_r [16];
  logic        ref_scc = 1'b0;

  localparam logic [8:0] TAG = 9'b101111101;

  always #5 clk = ~clk;

  scalar_unop_unit u_scalar_unop_unit (
    .clk(clk), .rst(rst), .gen_new(gen_new), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .done_valid(done_valid),
    .done_illegal(done_illegal), .scc(scc), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_data(ld_data), .peek_idx(peek_idx), .peek_data(peek_data)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 got %0d exp below 100000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [31:0] v);
    ld_en = 1'b1; ld_idx = 4'(idx); ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    ref_r[idx] = v;
  endtask

  task automatic peek_chk(input int idx, input string req);
    peek_idx = 4'(idx);
    @(negedge clk);
    chk(peek_data === ref_r[idx], req, 64'(peek_data), 64'(ref_r[idx]));
  endtask

  task automatic issue(input logic [31:0] w, input bit exp_ill, input string req);
    in_valid = 1'b1; in_word = w;
    @(negedge clk);
    in_valid = 1'b0;
    chk(done_valid === 1'b1, {req, " done R9"}, 64'(done_valid), 64'd1);
    chk(done_illegal === exp_ill, {req, " illegal"}, 64'(done_illegal), 64'(exp_ill));
    chk(scc === ref_scc, {req, " flag"}, 64'(scc), 64'(ref_scc));
  endtask

  function automatic logic [31:0] word(input int opc, input int s, input int d);
    return {TAG, 7'(d), 8'(opc), 8'(s)};
  endfunction

  function automatic int opcode_of(input int k, input int w, input bit g);
    return (g ? 0 : 3) + 2 * k + w;
  endfunction

  // k: 0 MOV R3, 1 CMOV R4, 2 NOT R5, 3 QMASK R6, 4 REV R7
  task automatic run(input int k, input int w, input int s, input int d,
                     input bit g, input string req);
    logic [63:0] src, res, msk;
    bit wr;
    int n;
    n   = w ? 64 : 32;
    msk = w ? '1 : 64'h0000_0000_FFFF_FFFF;
    src = w ? {ref_r[s+1], ref_r[s]} : {32'b0, ref_r[s]};
    res = src;
    wr  = 1'b1;
    case (k)
      1: wr = ref_scc;
      2: begin res = ~src & msk; ref_scc = (res != 0); end
      3: begin
        res = '0;
        for (int gi = 0; gi < n / 4; gi++)
          if (((src >> (4 * gi)) & 64'hF) != 0) res |= 64'hF << (4 * gi);
        ref_scc = (res != 0);
      end
      4: begin
        res = '0;
        for (int i = 0; i < n; i++) res[n-1-i] = src[i];
      end
      default: ;
    endcase
    if (wr) begin
      ref_r[d] = res[31:0];
      if (w) ref_r[d+1] = res[63:32];
    end
    gen_new = g;
    issue(word(opcode_of(k, w, g), s, d), 1'b0, req);
    peek_chk(d, {req, " low"});
    if (w) peek_chk(d + 1, {req, " high R8"});
  endtask

  task automatic set_flag(input bit b);
    load(14, b ? 32'h0 : 32'hFFFF_FFFF);
    run(2, 0, 14, 15, 1'b1, "R5 flag setup");
  endtask

  logic [63:0] pats [6];
  string nm [5];

  initial begin
    pats[0] = 64'h0;
    pats[1] = '1;
    pats[2] = 64'h1;
    pats[3] = 64'h8000_0000_0000_0000;
    pats[4] = 64'h0123_4567_89AB_CDEF;
    pats[5] = 64'h0000_F010_0800_0001;
    nm[0] = "R3 mov"; nm[1] = "R4 cmov"; nm[2] = "R5 not";
    nm[3] = "R6 qmask"; nm[4] = "R7 rev";

    repeat (4) @(negedge clk);
    chk(in_ready === 1'b0, "R10 ready in reset", 64'(in_ready), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1, "R10 ready", 64'(in_ready), 64'd1);
    chk(done_valid === 1'b0, "R10 done", 64'(done_valid), 64'd0);
    chk(scc === 1'b0, "R10 flag", 64'(scc), 64'd0);

    for (int i = 0; i < 16; i++) load(i, 32'h1111_1111 * i ^ 32'h00C0_FFEE);
    for (int i = 0; i < 16; i++) peek_chk(i, "R11 load/peek");

    // R2: full opcode sweep in both generations
    for (int g = 0; g < 2; g++) begin
      gen_new = g[0];
      for (int op = 0; op < 256; op++) begin
        bit legal;
        int b;
        b = g ? 0 : 3;
        legal = (op >= b) && (op < b + 10);
        in_valid = 1'b1; in_word = word(op, 2, 4);
        @(negedge clk);
        in_valid = 1'b0;
        chk(done_illegal === !legal, "R2 opcode sweep", 64'(done_illegal), 64'(!legal));
      end
    end
    for (int i = 0; i < 16; i++) load(i, 32'h1111_1111 * i ^ 32'h00C0_FFEE);
    set_flag(1'b0);

    // Operations across patterns and widths, alternating generations
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 5; k++) begin
        for (int w = 0; w < 2; w++) begin
          load(2, pats[p][31:0]);
          load(3, pats[p][63:32]);
          load(4, 32'hA5A5_A5A5);
          load(5, 32'h5A5A_5A5A);
          if (k == 1) begin
            set_flag(1'b0);
            run(k, w, 2, 4, p[0], "R4 cmov flag0");
            set_flag(1'b1);
          end
          run(k, w, 2, 4, p[0], nm[k]);
        end
      end
    end

    // R7 in place, R6 on a source that is its own destination
    load(8, 32'h0000_0003); load(9, 32'hC000_0000);
    run(4, 1, 8, 8, 1'b0, "R7 rev64 in place");
    run(3, 1, 8, 8, 1'b1, "R6 qmask64 in place");

    // R1: each tag bit flipped
    set_flag(1'b1);
    for (int t = 0; t < 9; t++) begin
      gen_new = 1'b1;
      issue(word(2, 2, 4) ^ (32'h1 << (23 + t)), 1'b1, "R1 bad tag");
      peek_chk(4, "R1 dst untouched");
    end
    // R8 illegal indices
    issue(word(1, 3, 4), 1'b1, "R8 odd src pair");
    peek_chk(4, "R8 dst untouched");
    issue(word(1, 2, 5), 1'b1, "R8 odd dst pair");
    peek_chk(5, "R8 dst untouched");
    issue(word(4, 16, 6), 1'b1, "R8 src range");
    peek_chk(6, "R8 dst untouched");
    issue(word(4, 2, 16), 1'b1, "R8 dst range");
    peek_chk(0, "R8 r0 untouched");
    issue(word(200, 2, 4), 1'b1, "R2 unknown opcode");
    peek_chk(4, "R2 dst untouched");

    // R9 back-to-back: MOV r2->r6 then NOT r6->r7 on consecutive cycles
    load(2, 32'h0F0F_0000);
    gen_new = 1'b1;
    in_valid = 1'b1; in_word = word(0, 2, 6);
    @(negedge clk);
    in_word = word(4, 6, 7);
    @(negedge clk);
    in_valid = 1'b0;
    ref_r[6] = 32'h0F0F_0000; ref_r[7] = 32'hF0F0_FFFF; ref_scc = 1'b1;
    chk(done_valid === 1'b1, "R9 back-to-back done", 64'(done_valid), 64'd1);
    peek_chk(7, "R9 back-to-back forward");

    finish_run();
  end
endmodule